// File: doc/BRIEF.md
# PLL Divider Candidate Search Engine

This engine finds settings for an integer PLL whose oscillator runs at twice the feedback multiplier times the comparison frequency. It is given a reference clock rate and a window for the oscillator rate. It walks the legal pre-divider values N. For each N it walks the legal feedback multiplier values M. Each (N, M) pair is offered to an external checker, together with the comparison frequency and the resulting oscillator frequency. The checker accepts or rejects each pair. The search stops on the first accepted pair, or reports that no pair was accepted.

All bounds come from integer divisions. These are done one quotient bit per cycle by a single shared restoring divider, and the walk waits while that divider is working. A reverse input makes both walks run from the high bound down toward the low bound. This lets a caller prefer large dividers over small ones.

Rates are unsigned integers in any unit the caller picks. The hardware limits are parameters: largest N, largest M, comparison-frequency window and oscillator ceiling.

Top module: `pll_cand_search`

## Requirements
- R1: The N walk covers lo_n = max(ceil(clkin/FINT_MAX), 1) up to hi_n = min(floor(clkin/FINT_MIN), N_MAX), and hi_n itself is never offered (so lo_n == hi_n offers nothing).
- R2: When lo_n > hi_n the engine raises done with found low and offers no candidate.
- R3: A candidate carries fint = floor(clkin/N) and dco = 2*M*fint.
- R4: For each N the M walk covers lo_m = max(ceil(ceil(pll_min/fint)/2), 1) up to hi_m = min(floor(floor(pll_max/fint)/2), floor(floor(DCO_MAX/fint)/2), M_MAX), with hi_m excluded.
- R5: A pll_max of zero removes the pll_max term from hi_m (treated as all ones).
- R6: With reverse high at start, each walk begins at its high bound and steps by -1 down to, but excluding, its low bound.
- R7: An N with lo_m > hi_m (or lo_m == hi_m) yields no candidate and the walk moves to the next N.
- R8: While cand_valid is high and neither cand_accept nor cand_reject is high, the next cycle still has cand_valid high with N, M, fint and dco unchanged.
- R9: cand_accept during a valid candidate ends the search the next cycle with done and found high and the accepted N and M still on the outputs. found stays high until the next start.
- R10: When every candidate has been rejected, done rises with found low.
- R11: After reset, done, found and cand_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (taken while idle or finished) |
| clkin_rate | input | RATE_W | Reference clock rate |
| pll_min | input | RATE_W | Lowest wanted oscillator rate |
| pll_max | input | RATE_W | Highest wanted oscillator rate, 0 = no limit |
| reverse | input | 1 | Walk both ranges downward |
| cand_valid | output | 1 | A candidate is on offer |
| cand_n | output | $clog2(N_MAX+1) | Candidate pre-divider |
| cand_m | output | $clog2(M_MAX+1) | Candidate multiplier |
| cand_fint | output | RATE_W | Candidate comparison frequency |
| cand_dco | output | RATE_W | Candidate oscillator frequency |
| cand_accept | input | 1 | Checker takes the candidate |
| cand_reject | input | 1 | Checker refuses the candidate |
| done | output | 1 | Search finished (held until next start) |
| found | output | 1 | A candidate was accepted |

## Verification
The bench aims at several corner cases:
- A reference rate whose N window is inverted, where a wrong comparison would offer a bogus divider.
- A window that collapses to a single value, where an inclusive end would offer the excluded bound.
- A minimum oscillator rate high enough to empty the M range for some N, where a design that fails to skip would offer an M above the bound or hang.
- A zero pll_max, where a literal divide-by-limit would clamp M to zero and find nothing.
- Reverse walks, where a wrong swap would visit candidates out of order.
- Random delays before each reply, which catch a candidate that drifts while it waits.
- Acceptance on the first candidate, which catches an off-by-one in the stop path.

// File: rtl/pll_cand_pkg.sv
package pll_cand_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NLO,
        ST_NHI,
        ST_NCHK,
        ST_FINT,
        ST_MLO,
        ST_MHI1,
        ST_MHI2,
        ST_MCHK,
        ST_OFFER,
        ST_DONE
    } srch_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } walk_ctl_t;

endpackage

// File: rtl/pll_cand_div.sv
module pll_cand_div #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [W-1:0]  acc;
    logic [W-1:0]  shq;
    logic [W-1:0]  dsr;
    logic [W:0]    trial;

    assign trial = {acc, shq[W-1]} - {1'b0, dsr};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            acc  <= '0;
            shq  <= '0;
            dsr  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy <= 1'b1;
                cnt  <= CW'(W);
                acc  <= '0;
                shq  <= dividend;
                dsr  <= divisor;
            end else if (busy) begin
                if (!trial[W]) begin
                    acc <= trial[W-1:0];
                    shq <= {shq[W-2:0], 1'b1};
                end else begin
                    acc <= {acc[W-2:0], shq[W-1]};
                    shq <= {shq[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = shq;
    assign rem = acc;
endmodule

// File: rtl/pll_cand_walk.sv
module pll_cand_walk #(
    parameter int CW = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pll_cand_pkg::walk_ctl_t ctl,
    input  logic [CW-1:0]         lo,
    input  logic [CW-1:0]         hi,
    input  logic                  rev,
    output logic [CW-1:0]         cur,
    output logic                  at_end
);
    logic [CW-1:0] endv;
    logic          down;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            endv <= '0;
            down <= 1'b0;
        end else if (ctl.load) begin
            cur  <= rev ? hi : lo;
            endv <= rev ? lo : hi;
            down <= rev;
        end else if (ctl.step) begin
            cur <= down ? cur - CW'(1) : cur + CW'(1);
        end
    end

    assign at_end = (cur == endv);
endmodule

// File: rtl/pll_cand_search.sv
module pll_cand_search
    import pll_cand_pkg::*;
#(
    parameter int RATE_W   = 24,
    parameter int N_MAX    = 16,
    parameter int M_MAX    = 255,
    parameter int FINT_MIN = 1000,
    parameter int FINT_MAX = 20000,
    parameter int DCO_MAX  = 4000000,
    localparam int NW = $clog2(N_MAX + 1),
    localparam int MW = $clog2(M_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] clkin_rate,
    input  logic [RATE_W-1:0] pll_min,
    input  logic [RATE_W-1:0] pll_max,
    input  logic              reverse,
    output logic              cand_valid,
    output logic [NW-1:0]     cand_n,
    output logic [MW-1:0]     cand_m,
    output logic [RATE_W-1:0] cand_fint,
    output logic [RATE_W-1:0] cand_dco,
    input  logic              cand_accept,
    input  logic              cand_reject,
    output logic              done,
    output logic              found
);
    localparam logic [RATE_W-1:0] NMAX_V = RATE_W'(N_MAX);
    localparam logic [RATE_W-1:0] MMAX_V = RATE_W'(M_MAX);
    localparam logic [RATE_W-1:0] FMIN_V = RATE_W'(FINT_MIN);
    localparam logic [RATE_W-1:0] FMAX_V = RATE_W'(FINT_MAX);
    localparam logic [RATE_W-1:0] DCO_V  = RATE_W'(DCO_MAX);
    localparam logic [RATE_W-1:0] ONE_V  = RATE_W'(1);

    srch_state_e st, st_nxt;

    logic [RATE_W-1:0] r_clkin, r_min, r_pmax;
    logic              r_rev;
    logic [RATE_W-1:0] fint_q, n_lo_w, m_lo_w, lim1;

    logic              div_go, div_done;
    logic [RATE_W-1:0] div_a, div_b, div_q, div_r;

    walk_ctl_t         n_ctl, m_ctl;
    logic [NW-1:0]     n_cur;
    logic [MW-1:0]     m_cur;
    logic              n_end, m_end;

    logic [RATE_W:0]   ceil_w, half_up;
    logic [RATE_W-1:0] n_hi_c, m_hi_c, m_hi_a, q_half;
    logic              taking_start;

    assign ceil_w  = {1'b0, div_q} + {{RATE_W{1'b0}}, (div_r != '0)};
    assign half_up = (ceil_w + {{RATE_W{1'b0}}, 1'b1}) >> 1;
    assign q_half  = div_q >> 1;
    assign n_hi_c  = (div_q < NMAX_V) ? div_q : NMAX_V;
    assign m_hi_a  = (lim1 < q_half) ? lim1 : q_half;
    assign m_hi_c  = (m_hi_a < MMAX_V) ? m_hi_a : MMAX_V;
    assign taking_start = start && (st == ST_IDLE || st == ST_DONE);

    pll_cand_div #(.W(RATE_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go),
        .dividend(div_a), .divisor(div_b),
        .done(div_done), .quo(div_q), .rem(div_r)
    );

    pll_cand_walk #(.CW(NW)) u_nwalk (
        .clk(clk), .rst(rst), .ctl(n_ctl),
        .lo(NW'(n_lo_w)), .hi(NW'(n_hi_c)), .rev(r_rev),
        .cur(n_cur), .at_end(n_end)
    );

    pll_cand_walk #(.CW(MW)) u_mwalk (
        .clk(clk), .rst(rst), .ctl(m_ctl),
        .lo(MW'(m_lo_w)), .hi(MW'(m_hi_c)), .rev(r_rev),
        .cur(m_cur), .at_end(m_end)
    );

    always_comb begin
        st_nxt = st;
        div_go = 1'b0;
        div_a  = r_clkin;
        div_b  = FMAX_V;
        n_ctl  = '0;
        m_ctl  = '0;
        unique case (st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    div_go = 1'b1;
                    div_a  = clkin_rate;
                    div_b  = FMAX_V;
                    st_nxt = ST_NLO;
                end
            end
            ST_NLO: begin
                if (div_done) begin
                    div_go = 1'b1;
                    div_b  = FMIN_V;
                    st_nxt = ST_NHI;
                end
            end
            ST_NHI: begin
                if (div_done) begin
                    if (n_lo_w > n_hi_c) begin
                        st_nxt = ST_DONE;
                    end else begin
                        n_ctl.load = 1'b1;
                        st_nxt     = ST_NCHK;
                    end
                end
            end
            ST_NCHK: begin
                if (n_end) begin
                    st_nxt = ST_DONE;
                end else begin
                    div_go = 1'b1;
                    div_b  = RATE_W'(n_cur);
                    st_nxt = ST_FINT;
                end
            end
            ST_FINT: begin
                if (div_done) begin
                    div_go = 1'b1;
                    div_a  = r_min;
                    div_b  = div_q;
                    st_nxt = ST_MLO;
                end
            end
            ST_MLO: begin
                if (div_done) begin
                    div_go = 1'b1;
                    div_a  = r_pmax;
                    div_b  = fint_q;
                    st_nxt = ST_MHI1;
                end
            end
            ST_MHI1: begin
                if (div_done) begin
                    div_go = 1'b1;
                    div_a  = DCO_V;
                    div_b  = fint_q;
                    st_nxt = ST_MHI2;
                end
            end
            ST_MHI2: begin
                if (div_done) begin
                    if (m_lo_w > m_hi_c) begin
                        n_ctl.step = 1'b1;
                        st_nxt     = ST_NCHK;
                    end else begin
                        m_ctl.load = 1'b1;
                        st_nxt     = ST_MCHK;
                    end
                end
            end
            ST_MCHK: begin
                if (m_end) begin
                    n_ctl.step = 1'b1;
                    st_nxt     = ST_NCHK;
                end else begin
                    st_nxt = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (cand_accept) begin
                    st_nxt = ST_DONE;
                end else if (cand_reject) begin
                    m_ctl.step = 1'b1;
                    st_nxt     = ST_MCHK;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            r_clkin <= '0;
            r_min   <= '0;
            r_pmax  <= '0;
            r_rev   <= 1'b0;
            fint_q  <= '0;
            n_lo_w  <= '0;
            m_lo_w  <= '0;
            lim1    <= '0;
            done    <= 1'b0;
            found   <= 1'b0;
        end else begin
            st <= st_nxt;
            if (taking_start) begin
                r_clkin <= clkin_rate;
                r_min   <= pll_min;
                r_pmax  <= (pll_max == '0) ? '1 : pll_max;
                r_rev   <= reverse;
                done    <= 1'b0;
                found   <= 1'b0;
            end
            if (div_done) begin
                unique case (st)
                    ST_NLO:  n_lo_w <= (ceil_w == '0) ? ONE_V : RATE_W'(ceil_w);
                    ST_FINT: fint_q <= div_q;
                    ST_MLO:  m_lo_w <= (half_up == '0) ? ONE_V : RATE_W'(half_up);
                    ST_MHI1: lim1   <= q_half;
                    default: ;
                endcase
            end
            if (st != ST_DONE && st_nxt == ST_DONE) begin
                done <= 1'b1;
                if (st == ST_OFFER) found <= 1'b1;
            end
        end
    end

    assign cand_valid = (st == ST_OFFER);
    assign cand_n     = n_cur;
    assign cand_m     = m_cur;
    assign cand_fint  = fint_q;
    assign cand_dco   = RATE_W'(fint_q * RATE_W'(m_cur) * RATE_W'(2));
endmodule

// File: rtl/pll_cand_search_chk.sv
module pll_cand_search_chk #(
    parameter int RATE_W   = 24,
    parameter int N_MAX    = 16,
    parameter int M_MAX    = 255,
    parameter int FINT_MIN = 1000,
    parameter int FINT_MAX = 20000,
    parameter int DCO_MAX  = 4000000,
    localparam int NW = $clog2(N_MAX + 1),
    localparam int MW = $clog2(M_MAX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              cand_valid,
    input logic [NW-1:0]     cand_n,
    input logic [MW-1:0]     cand_m,
    input logic [RATE_W-1:0] cand_fint,
    input logic [RATE_W-1:0] cand_dco,
    input logic              cand_accept,
    input logic              cand_reject,
    input logic              done,
    input logic              found
);
    a_r8_cand_stable: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && !cand_accept && !cand_reject) |=>
        (cand_valid && $stable(cand_n) && $stable(cand_m) &&
         $stable(cand_fint) && $stable(cand_dco)));

    a_r9_accept_ends: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && cand_accept) |=>
        (done && found && !cand_valid && $stable(cand_n) && $stable(cand_m)));

    a_r9_found_held: assert property (@(posedge clk) disable iff (rst)
        (found && !start) |=> found);

    a_r9_found_means_done: assert property (@(posedge clk) disable iff (rst)
        found |-> done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !cand_valid);

    a_r1_n_range: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (cand_n >= NW'(1) && cand_n <= NW'(N_MAX)));

    a_r4_m_range: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (cand_m >= MW'(1) && cand_m <= MW'(M_MAX)));

    a_r3_rate_window: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (cand_dco <= RATE_W'(DCO_MAX) &&
                        cand_fint >= RATE_W'(FINT_MIN) &&
                        cand_fint <= RATE_W'(FINT_MAX)));
endmodule

bind pll_cand_search pll_cand_search_chk #(
    .RATE_W(RATE_W), .N_MAX(N_MAX), .M_MAX(M_MAX),
    .FINT_MIN(FINT_MIN), .FINT_MAX(FINT_MAX), .DCO_MAX(DCO_MAX)
) u_chk (
    .clk(clk), .rst(rst), .start(start),
    .cand_valid(cand_valid), .cand_n(cand_n), .cand_m(cand_m),
    .cand_fint(cand_fint), .cand_dco(cand_dco),
    .cand_accept(cand_accept), .cand_reject(cand_reject),
    .done(done), .found(found)
);

// File: tb/pll_cand_search_bench.sv
module pll_cand_search_bench;
    localparam int RW   = 24;
    localparam int NM   = 12;
    localparam int MM   = 40;
    localparam int FMIN = 1000;
    localparam int FMAX = 20000;
    localparam int DCOM = 4000000;
    localparam int NW   = $clog2(NM + 1);
    localparam int MW   = $clog2(MM + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [RW-1:0] clkin_rate = '0;
    logic [RW-1:0] pll_min = '0;
    logic [RW-1:0] pll_max = '0;
    logic          reverse = 1'b0;
    logic          cand_valid;
    logic [NW-1:0] cand_n;
    logic [MW-1:0] cand_m;
    logic [RW-1:0] cand_fint;
    logic [RW-1:0] cand_dco;
    logic          cand_accept = 1'b0;
    logic          cand_reject = 1'b0;
    logic          done;
    logic          found;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pll_cand_search #(
        .RATE_W(RW), .N_MAX(NM), .M_MAX(MM),
        .FINT_MIN(FMIN), .FINT_MAX(FMAX), .DCO_MAX(DCOM)
    ) u_pll_cand_search (
        .clk(clk), .rst(rst), .start(start),
        .clkin_rate(clkin_rate), .pll_min(pll_min), .pll_max(pll_max),
        .reverse(reverse), .cand_valid(cand_valid),
        .cand_n(cand_n), .cand_m(cand_m),
        .cand_fint(cand_fint), .cand_dco(cand_dco),
        .cand_accept(cand_accept), .cand_reject(cand_reject),
        .done(done), .found(found)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint lmin(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

    task automatic wait_evt(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (cand_valid || done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_case(input longint ci, input longint pmn, input longint pmx,
                            input bit rev, input int k, input string endtag);
        longint nlo, nhi, ns, ne, st, fint, c, mlo, mhi, pe, ms, me;
        bit     stop, seen, hold;
        int     idx;
        string  ntag, mtag;
        @(negedge clk);
        clkin_rate = RW'(ci);
        pll_min    = RW'(pmn);
        pll_max    = RW'(pmx);
        reverse    = rev;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        ntag = rev ? "R6" : "R1";
        mtag = (pmx == 0) ? "R5" : (rev ? "R6" : "R4");
        stop = 1'b0;
        idx  = 0;
        nlo = (ci + FMAX - 1) / FMAX;
        if (nlo < 1) nlo = 1;
        nhi = lmin(ci / FMIN, NM);
        if (nlo <= nhi) begin
            ns = rev ? nhi : nlo;
            ne = rev ? nlo : nhi;
            st = rev ? -1 : 1;
            for (longint n = ns; n != ne && !stop; n += st) begin
                fint = ci / n;
                c    = (pmn + fint - 1) / fint;
                mlo  = (c + 1) / 2;
                if (mlo < 1) mlo = 1;
                pe   = (pmx == 0) ? 64'hFFFFFF : pmx;
                mhi  = lmin(lmin((pe / fint) / 2, (DCOM / fint) / 2), MM);
                if (mlo > mhi) continue;
                ms = rev ? mhi : mlo;
                me = rev ? mlo : mhi;
                for (longint m = ms; m != me; m += st) begin
                    wait_evt(seen);
                    if (!seen || !cand_valid) begin
                        chk(1'b0, "R3 candidate missing", longint'(cand_valid), 1);
                        stop = 1'b1;
                        break;
                    end
                    chk(longint'(cand_n) == n, ntag, longint'(cand_n), n);
                    chk(longint'(cand_m) == m, mtag, longint'(cand_m), m);
                    chk(longint'(cand_fint) == fint, "R3 fint", longint'(cand_fint), fint);
                    chk(longint'(cand_dco) == 2 * m * fint, "R3 dco", longint'(cand_dco), 2 * m * fint);
                    hold = ($urandom % 5) == 0;
                    if (hold) begin
                        repeat (2) @(negedge clk);
                        chk(cand_valid && longint'(cand_m) == m && longint'(cand_n) == n,
                            "R8 held candidate", longint'(cand_m), m);
                    end
                    if (idx == k) cand_accept = 1'b1;
                    else          cand_reject = 1'b1;
                    @(negedge clk);
                    cand_accept = 1'b0;
                    cand_reject = 1'b0;
                    if (idx == k) begin
                        chk(done && found && !cand_valid, "R9 done/found", {done, found}, 3);
                        chk(longint'(cand_n) == n && longint'(cand_m) == m,
                            "R9 accepted pair held", longint'(cand_m), m);
                        stop = 1'b1;
                        break;
                    end
                    idx++;
                end
            end
        end
        if (!stop) begin
            wait_evt(seen);
            chk(seen && done && !found && !cand_valid, endtag,
                {cand_valid, done, found}, 2);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        longint ci, pmn, pmx;
        int     k;
        void'($urandom(32'd1522));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !found && !cand_valid, "R11 reset state",
            {cand_valid, done, found}, 0);

        run_case(500, 0, 0, 1'b0, -1, "R2 empty N range");
        run_case(1500, 0, 0, 1'b0, -1, "R1 single-value N range");
        run_case(38400, 500000, 3000000, 1'b0, -1, "R10 exhausted");
        run_case(38400, 500000, 3000000, 1'b1, -1, "R6 exhausted reverse");
        run_case(38400, 1000000, 0, 1'b0, -1, "R7 some N skipped");
        run_case(38400, 3990000, 0, 1'b0, -1, "R7 all M empty");
        run_case(38400, 200000, 0, 1'b0, -1, "R5 unlimited max");
        run_case(26000, 300000, 2000000, 1'b0, 0, "R9 first accepted");
        run_case(26000, 300000, 2000000, 1'b1, 7, "R9 reverse accept");

        for (int t = 0; t < 14; t++) begin
            ci  = 1000 + ($urandom % 240000);
            pmn = $urandom % 3000000;
            pmx = (($urandom % 3) == 0) ? 0 : pmn + ($urandom % 1500000);
            k   = (($urandom % 3) == 0) ? -1 : int'($urandom % 60);
            run_case(ci, pmn, pmx, 1'($urandom % 2), k, "R10 random end");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule